// File: doc/BRIEF.md
# Cascadable Timer Compare Unit

A timer with a 4-bit low stage and an 8-bit high stage, each paired with its own compare register. The stages either run side by side or join into one 12-bit counter. When they run separately, the low stage can act as a prescaler that feeds the high stage. The high stage, or the joined 12-bit counter, is the main stage. Its compare match and its overflow drive a toggle flip-flop, an optional counter clear and an interrupt pulse. Four bits of a mode register select these actions.

Software writes the mode register and the compare registers through a 4-bit write port that carries an address and a subaddress. Counting advances only on cycles where `cnt_en` is high. The counter arrangement (`ctr_mode`) and the output mode (`out_mode`) are static inputs supplied by the surrounding timer. All outputs are registered and change one clock after the tick that causes them.

Top module: `cascade_timer`

## Requirements
- R1: After reset, `tog`, `irq` and `next_ce` are 0. The mode register is 0000, the low compare register is 1111, the high compare register is 0xFF and both counters are 0.
- R2: A write takes effect only when `wr_addr` is 7. At that address, subaddress 3 loads the mode register, subaddress 4 loads the low compare register, subaddress 5 loads high compare bits 3:0 and subaddress 6 loads high compare bits 7:4. Writes to any other address change nothing.
- R3: With `ctr_mode`=0 (independent), both stages advance on every `cnt_en` tick. A low-stage tick at the low compare value is a low event: it restarts the low counter at 0 and pulses `next_ce` one cycle later. A high-stage tick at the high compare value is a compare match. A high-stage tick at 0xFF is an overflow.
- R4: With `ctr_mode`=2 or 3 (joined), the two stages form one 12-bit counter {high,low}. A match occurs at {high compare, low compare}, an overflow occurs at 0xFFF, and `next_ce` pulses after each tick taken at low nibble 0xF.
- R5: With `ctr_mode`=1 (prescaler), the high stage advances only on low events, and `next_ce` follows the high-stage tick. If the low compare register holds 0, every `cnt_en` tick goes straight to the high stage.
- R6: When mode bit 1 is set, a compare match clears the main counter to 0 in place of incrementing it. Otherwise the counter wraps past its maximum.
- R7: Mode bit 3 makes an overflow toggle `tog`, and mode bit 2 makes a compare match toggle it. If both fire on the same tick, `tog` toggles once.
- R8: The interrupt source is the compare match when `out_mode` is 7 and mode bit 2 is set. In every other case it is the overflow when mode bit 3 is set and the compare match when it is clear.
- R9: `irq` is a one-cycle pulse for each source event, and it is issued only while mode bit 0 is set.
- R10: On a cycle that writes any compare register (subaddress 4, 5 or 6), no compare match and no low event occur. A low stage blocked this way increments instead of restarting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_sub | input | 4 | Write subaddress |
| wr_data | input | 4 | Write data nibble |
| cnt_en | input | 1 | Count tick |
| ctr_mode | input | 2 | 0 independent, 1 prescaler, 2/3 joined 12-bit |
| out_mode | input | 3 | Output mode of the surrounding timer |
| tog | output | 1 | Toggle flip-flop |
| next_ce | output | 1 | Clock enable for the next stage |
| irq | output | 1 | Interrupt pulse |

## Verification
The counters and compare registers cannot be read, so a wrong counter value appears only as an `irq`, `tog` or `next_ce` edge at the wrong time. That edge can surface as late as one full count period after the fault, which is up to 4096 ticks in joined mode. The bench therefore runs every mode well beyond one wrap so that each output edge is compared cycle by cycle against a reference model. A lost compare suppression or a wrong clear-on-match shifts every later event, so these faults show up no later than the next period.

// File: rtl/cascade_timer.sv
module cascade_timer #(
  parameter logic [3:0] BLK_ADDR   = 4'h7,
  parameter logic [3:0] SUB_MODE   = 4'h3,
  parameter logic [3:0] SUB_CMP_LO = 4'h4,
  parameter logic [3:0] SUB_CMP_HL = 4'h5,
  parameter logic [3:0] SUB_CMP_HH = 4'h6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [3:0] wr_sub,
  input  logic [3:0] wr_data,
  input  logic       cnt_en,
  input  logic [1:0] ctr_mode,
  input  logic [2:0] out_mode,
  output logic       tog,
  output logic       next_ce,
  output logic       irq
);
  localparam int LO_W   = 4;
  localparam int HI_W   = 8;
  localparam int FULL_W = LO_W + HI_W;

  logic [3:0]        mode_q;
  logic [LO_W-1:0]   cmp_lo;
  logic [HI_W-1:0]   cmp_hi;
  logic [LO_W-1:0]   lo_q;
  logic [HI_W-1:0]   hi_q;

  wire blk_sel = wr_en && (wr_addr == BLK_ADDR);
  wire cmp_wr  = blk_sel && (wr_sub == SUB_CMP_LO || wr_sub == SUB_CMP_HL || wr_sub == SUB_CMP_HH);

  wire ovf_tg = mode_q[3];
  wire cmp_tg = mode_q[2];
  wire clr_m  = mode_q[1];
  wire int_en = mode_q[0];

  wire joined = ctr_mode[1];
  wire presc  = (ctr_mode == 2'd1);
  wire bypass = presc && (cmp_lo == '0);

  wire [FULL_W-1:0] full = {hi_q, lo_q};

  wire lo_evt    = cnt_en && (lo_q == cmp_lo) && !cmp_wr;
  wire hi_tick   = joined ? cnt_en : (presc ? (bypass ? cnt_en : lo_evt) : cnt_en);
  wire stage_out = joined ? (cnt_en && (&lo_q)) : (presc ? hi_tick : lo_evt);

  wire m_evt = hi_tick && !cmp_wr && (joined ? (full == {cmp_hi, cmp_lo}) : (hi_q == cmp_hi));
  wire o_evt = hi_tick && (joined ? (&full) : (&hi_q));

  wire src  = (out_mode == 3'd7 && cmp_tg) ? m_evt : (ovf_tg ? o_evt : m_evt);
  wire flip = (ovf_tg && o_evt) || (cmp_tg && m_evt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 4'h0;
      cmp_lo <= '1;
      cmp_hi <= '1;
    end else if (blk_sel) begin
      if (wr_sub == SUB_MODE)   mode_q      <= wr_data;
      if (wr_sub == SUB_CMP_LO) cmp_lo      <= wr_data;
      if (wr_sub == SUB_CMP_HL) cmp_hi[3:0] <= wr_data;
      if (wr_sub == SUB_CMP_HH) cmp_hi[7:4] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (joined) begin
      if (cnt_en) {hi_q, lo_q} <= (m_evt && clr_m) ? '0 : full + 1'b1;
    end else begin
      if (cnt_en)  lo_q <= lo_evt ? '0 : lo_q + 1'b1;
      if (hi_tick) hi_q <= (m_evt && clr_m) ? '0 : hi_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tog     <= 1'b0;
      next_ce <= 1'b0;
      irq     <= 1'b0;
    end else begin
      tog     <= tog ^ flip;
      next_ce <= stage_out;
      irq     <= int_en && src;
    end
  end
endmodule

module cascade_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [3:0] wr_addr,
  input logic [3:0] wr_sub,
  input logic       cnt_en,
  input logic [1:0] ctr_mode,
  input logic       tog,
  input logic       next_ce,
  input logic       irq,
  input logic [3:0] mode_q,
  input logic [3:0] cmp_lo
);
  // R9
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> $past(mode_q[0]));
  // R7
  tog_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(tog) |-> $past(cnt_en));
  // R3
  ce_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n) (next_ce || irq) |-> $past(cnt_en));
  // R2
  mode_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(wr_en && wr_addr == 4'h7 && wr_sub == 4'h3));
  // R5
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_mode == 2'd1 && cmp_lo == 4'h0 && cnt_en) |=> next_ce);
endmodule

bind cascade_timer cascade_timer_chk chk (.*);

// File: tb/tb_cascade_timer.sv
module tb_cascade_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0, wr_sub = '0, wr_data = '0;
  logic cnt_en = 1'b0;
  logic [1:0] ctr_mode = '0;
  logic [2:0] out_mode = 3'd1;
  logic tog, next_ce, irq;

  always #4 clk = ~clk;

  cascade_timer dut (.*);

  int total = 0, bad = 0;
  bit finished = 0;
  string tag = "R1";

  logic [3:0] m_mode, m_cl, m_lo;
  logic [7:0] m_ch, m_hi;
  logic e_tog, e_irq, e_nce;

  task automatic model_reset();
    m_mode = 4'h0; m_cl = 4'hF; m_ch = 8'hFF; m_lo = '0; m_hi = '0;
    e_tog = 0; e_irq = 0; e_nce = 0;
  endtask

  task automatic model_step(logic we, logic [3:0] a, logic [3:0] s, logic [3:0] d, logic ce);
    logic sel, sup, me, oe, le, ht, byp, srcv;
    logic [11:0] v;
    sel = we && a == 4'h7;
    sup = sel && (s == 4'h4 || s == 4'h5 || s == 4'h6);
    if (ctr_mode[1]) begin
      v  = {m_hi, m_lo};
      me = ce && v == {m_ch, m_cl} && !sup;
      oe = ce && v == 12'hFFF;
      e_nce = ce && m_lo == 4'hF;
      if (ce) {m_hi, m_lo} = (me && m_mode[1]) ? 12'h000 : v + 12'h001;
    end else begin
      le  = ce && m_lo == m_cl && !sup;
      byp = ctr_mode == 2'd1 && m_cl == 4'h0;
      ht  = (ctr_mode == 2'd1) ? (byp ? ce : le) : ce;
      e_nce = (ctr_mode == 2'd1) ? ht : le;
      me = ht && m_hi == m_ch && !sup;
      oe = ht && m_hi == 8'hFF;
      if (ce) m_lo = le ? 4'h0 : m_lo + 4'h1;
      if (ht) m_hi = (me && m_mode[1]) ? 8'h00 : m_hi + 8'h01;
    end
    srcv  = (out_mode == 3'd7 && m_mode[2]) ? me : (m_mode[3] ? oe : me);
    e_irq = m_mode[0] && srcv;
    e_tog = e_tog ^ ((m_mode[3] && oe) || (m_mode[2] && me));
    if (sel) begin
      if (s == 4'h3) m_mode = d;
      if (s == 4'h4) m_cl = d;
      if (s == 4'h5) m_ch[3:0] = d;
      if (s == 4'h6) m_ch[7:4] = d;
    end
  endtask

  task automatic chk(string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(logic we, logic [3:0] a, logic [3:0] s, logic [3:0] d, logic ce);
    wr_en = we; wr_addr = a; wr_sub = s; wr_data = d; cnt_en = ce;
    model_step(we, a, s, d, ce);
    @(negedge clk);
    chk("tog", tog, e_tog);
    chk("irq", irq, e_irq);
    chk("next_ce", next_ce, e_nce);
  endtask

  task automatic wr(logic [3:0] s, logic [3:0] d);
    cyc(1'b1, 4'h7, s, d, 1'b0);
  endtask

  task automatic run(int n, int ce_pct, int wr_pct, logic [3:0] hh);
    for (int i = 0; i < n; i++) begin
      logic ce;
      ce = ($urandom % 100) < ce_pct;
      if (($urandom % 100) < wr_pct) begin
        int k;
        k = $urandom % 3;
        if (k == 0)      cyc(1'b1, 4'h7, 4'h4, 4'($urandom % 16), ce);
        else if (k == 1) cyc(1'b1, 4'h7, 4'h5, 4'($urandom % 16), ce);
        else             cyc(1'b1, 4'h7, 4'h6, hh, ce);
      end else cyc(1'b0, 4'h0, 4'h0, 4'h0, ce);
    end
  endtask

  task automatic set_cmp(logic [3:0] lo, logic [7:0] hi);
    wr(4'h4, lo); wr(4'h5, hi[3:0]); wr(4'h6, hi[7:4]);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state of outputs, then default compare values seen through next_ce
    tag = "R1";
    chk("tog", tog, 1'b0); chk("irq", irq, 1'b0); chk("next_ce", next_ce, 1'b0);
    rst_n = 1'b1;
    ctr_mode = 2'd0;
    run(300, 100, 0, 4'h0);
    // R3: independent stages, compare match interrupts
    tag = "R3";
    wr(4'h3, 4'b0101); set_cmp(4'h5, 8'h07);
    run(800, 70, 0, 4'h0);
    // R6: clear on match
    tag = "R6";
    wr(4'h3, 4'b0111); set_cmp(4'h3, 8'h09);
    run(600, 80, 2, 4'h0);
    // R4: joined 12-bit with match and then wrap through 0xFFF
    tag = "R4";
    ctr_mode = 2'd2;
    wr(4'h3, 4'b0111); set_cmp(4'h9, 8'h02);
    run(600, 90, 0, 4'h0);
    wr(4'h3, 4'b1001); set_cmp(4'h0, 8'h10);
    run(4300, 100, 0, 4'h0);
    ctr_mode = 2'd3;
    run(200, 60, 1, 4'h0);
    // R5: prescaler feed, then bypass with low compare at 0
    tag = "R5";
    ctr_mode = 2'd1;
    wr(4'h3, 4'b0111); set_cmp(4'h2, 8'h04);
    run(500, 80, 0, 4'h0);
    wr(4'h4, 4'h0);
    run(400, 70, 0, 4'h0);
    // R7: overflow and match on the same tick toggle once
    tag = "R7";
    ctr_mode = 2'd0;
    wr(4'h3, 4'b1100); set_cmp(4'h1, 8'hFF);
    run(1100, 100, 0, 4'h0);
    wr(4'h3, 4'b1110); set_cmp(4'h6, 8'h0B);
    run(600, 80, 0, 4'h0);
    // R8: interrupt source by output mode and mask bits
    tag = "R8";
    out_mode = 3'd7;
    wr(4'h3, 4'b1111); set_cmp(4'h3, 8'h05);
    run(400, 80, 0, 4'h0);
    wr(4'h3, 4'b1001);
    run(700, 100, 0, 4'h0);
    out_mode = 3'd4;
    wr(4'h3, 4'b1111);
    run(600, 100, 0, 4'h0);
    // R9: interrupt masked
    tag = "R9";
    out_mode = 3'd2;
    wr(4'h3, 4'b0110); set_cmp(4'h2, 8'h03);
    run(300, 90, 0, 4'h0);
    // R10: compare writes during counting suppress events
    tag = "R10";
    wr(4'h3, 4'b0111); set_cmp(4'h4, 8'h03);
    for (int i = 0; i < 4; i++) cyc(1'b0, 4'h0, 4'h0, 4'h0, 1'b1);
    cyc(1'b1, 4'h7, 4'h5, 4'h3, 1'b1);
    run(1500, 90, 30, 4'h0);
    ctr_mode = 2'd2;
    run(800, 90, 25, 4'h0);
    ctr_mode = 2'd1;
    run(800, 90, 25, 4'h0);
    // R2: writes to a foreign address and unused subaddresses change nothing
    tag = "R2";
    ctr_mode = 2'd0;
    wr(4'h3, 4'b0101); set_cmp(4'h3, 8'h04);
    for (int i = 0; i < 400; i++) begin
      logic ce;
      ce = ($urandom % 100) < 80;
      if (i % 3 == 0)      cyc(1'b1, 4'h6, 4'(3 + $urandom % 4), 4'($urandom % 16), ce);
      else if (i % 3 == 1) cyc(1'b1, 4'h7, 4'(7 + $urandom % 8), 4'($urandom % 16), ce);
      else                 cyc(1'b0, 4'h7, 4'h3, 4'h0, ce);
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule